// File: doc/BRIEF.md
# Byte-wide counter register interface

This block sits between an 8-bit processor bus and one 24-bit counter channel. The processor reaches the channel's 24-bit registers one byte at a time. A single address bit, the command/data select, splits each bus transfer into one of two spaces. A write in command space runs a command byte: choose the system mode, aim the access pointer, or fire a load or latch strobe toward the counter. A read in command space returns the channel status byte.

A transfer in data space reads or writes one byte of the register that the access pointer names. After every such transfer the byte pointer moves on by itself, from low to middle to high and back to low. Software therefore sets only the starting point and then streams bytes. The latch register is read-only and comes in from the counter datapath. The preload and the two compare values are held here and are driven out to that datapath.

Strobes are single-cycle, synchronous to `clk`. Read data is combinational from the current pointer. The pointer moves at the clock edge that ends the read.

Top module: `ctr_bus_if`

## Requirements
- R1: After reset the system mode is 0, the pointer names the preload register (slot 0) at its low byte, all held registers are zero, and both strobes are low.
- R2: A command-space write of 91h sets the system mode to 1 and 90h sets it to 0. Any other command byte leaves the mode unchanged.
- R3: A command-space write whose upper nibble is 0 sets the pointer. Bits 3:2 pick the slot (0 preload, 1 compare A, 2 compare B, 3 latch). Bits 1:0 pick the starting byte (0 low, 1 middle, 2 high, and 3 is treated as low).
- R4: A data-space write replaces only the byte lane [8*b+7:8*b] of the addressed slot, where b is the current byte pointer. The other two bytes keep their values.
- R5: Each data-space read or write moves the byte pointer low→middle→high→low and leaves the slot unchanged.
- R6: During a data-space read, the output carries the addressed byte of the addressed slot. Slot 3 takes its bytes from the latch input.
- R7: A command-space read drives the status input onto the output and does not move the pointer.
- R8: A data-space write to slot 3 changes no held register but still moves the byte pointer.
- R9: Command 20h gives a one-cycle load strobe and command 21h a one-cycle latch strobe, each in the cycle after the write.
- R10: Command bytes other than 90h, 91h, 20h, 21h and the pointer form have no effect. With no strobe on the bus, the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busData | input | 8 | Write data byte from the processor |
| cmdSel | input | 1 | 1 = command space, 0 = data space |
| wrStb | input | 1 | Write strobe, one cycle per byte |
| rdStb | input | 1 | Read strobe, one cycle per byte |
| statusIn | input | 8 | Channel status byte |
| latchIn | input | 24 | Latched counter value |
| busDataOut | output | 8 | Read data byte |
| sysMode | output | 1 | Current system mode |
| loadStb | output | 1 | Load-preload-into-counter pulse |
| latchStb | output | 1 | Capture-counter-into-latch pulse |
| preloadVal | output | 24 | Preload register |
| cmpAVal | output | 24 | Compare A register |
| cmpBVal | output | 24 | Compare B register |

## Verification
Byte streams are run through every slot, each starting from a different byte:
- A full three-byte write followed by four reads separates a correct wrap from a pointer that sticks at the high byte.
- A stream that starts at the high byte and runs into the low byte catches a pointer that resets to low instead of wrapping.
- Reads of the latch slot, with distinct values in each byte, expose byte-order swaps.
- A status read placed between a pointer command and a data read shows whether the status access wrongly moves the pointer.
- A starting byte of 3, a write into the latch slot, and an unknown command byte each separate proper ignoring from state corruption.

// File: rtl/ctr_bus_pkg.sv
package ctr_bus_pkg;
  parameter int DATA_W        = 8;
  parameter int BYTES_PER_REG = 3;
  parameter int REG_COUNT     = 3;
  parameter int SLOT_COUNT    = REG_COUNT + 1;
  parameter int REG_W         = DATA_W * BYTES_PER_REG;
  parameter int BYTE_IDX_W    = $clog2(BYTES_PER_REG + 1);
  parameter int REG_IDX_W     = $clog2(SLOT_COUNT);
  parameter int PTR_BYTE_LSB  = 0;
  parameter int PTR_REG_LSB   = PTR_BYTE_LSB + BYTE_IDX_W;

  parameter logic [DATA_W-1:0] CMD_MODE0 = 8'h90;
  parameter logic [DATA_W-1:0] CMD_MODE1 = 8'h91;
  parameter logic [DATA_W-1:0] CMD_LOAD  = 8'h20;
  parameter logic [DATA_W-1:0] CMD_LATCH = 8'h21;

  typedef struct packed {
    logic [REG_COUNT-1:0]  regWe;
    logic [REG_IDX_W-1:0]  regIdx;
    logic [BYTE_IDX_W-1:0] byteIdx;
    logic [DATA_W-1:0]     wrByte;
  } strobeT;
endpackage

// File: rtl/ctr_bus_ctrl.sv
module ctr_bus_ctrl
  import ctr_bus_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busData,
  input  logic              cmdSel,
  input  logic              wrStb,
  input  logic              rdStb,
  output strobeT            stb,
  output logic              sysMode,
  output logic              loadStb,
  output logic              latchStb
);
  logic [REG_IDX_W-1:0]  regPtr;
  logic [BYTE_IDX_W-1:0] bytePtr;
  logic [BYTE_IDX_W-1:0] reqByte;
  logic [BYTE_IDX_W-1:0] startByte;
  logic [BYTE_IDX_W-1:0] nextByte;
  logic [REG_COUNT-1:0]  we;
  logic cmdWr, dataWr, dataRd, dataAcc, ptrCmd;

  assign cmdWr   = wrStb & cmdSel;
  assign dataWr  = wrStb & ~cmdSel;
  assign dataRd  = rdStb & ~cmdSel & ~wrStb;
  assign dataAcc = dataWr | dataRd;
  assign ptrCmd  = cmdWr && (busData[DATA_W-1:DATA_W-4] == 4'h0);

  assign reqByte   = busData[PTR_BYTE_LSB +: BYTE_IDX_W];
  assign startByte = (int'(reqByte) < BYTES_PER_REG) ? reqByte : '0;
  assign nextByte  = (int'(bytePtr) == BYTES_PER_REG - 1) ? '0 : bytePtr + 1'b1;

  always_comb begin
    we = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      we[i] = dataWr && (regPtr == REG_IDX_W'(i));
    end
  end

  assign stb = '{regWe: we, regIdx: regPtr, byteIdx: bytePtr, wrByte: busData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regPtr   <= '0;
      bytePtr  <= '0;
      sysMode  <= 1'b0;
      loadStb  <= 1'b0;
      latchStb <= 1'b0;
    end else begin
      loadStb  <= cmdWr && (busData == CMD_LOAD);
      latchStb <= cmdWr && (busData == CMD_LATCH);
      if (cmdWr && busData == CMD_MODE0) begin
        sysMode <= 1'b0;
      end else if (cmdWr && busData == CMD_MODE1) begin
        sysMode <= 1'b1;
      end
      if (ptrCmd) begin
        regPtr  <= busData[PTR_REG_LSB +: REG_IDX_W];
        bytePtr <= startByte;
      end else if (dataAcc) begin
        bytePtr <= nextByte;
      end
    end
  end
endmodule

// File: rtl/ctr_bus_dpath.sv
module ctr_bus_dpath
  import ctr_bus_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  strobeT                     stb,
  input  logic                       cmdSel,
  input  logic [DATA_W-1:0]          statusIn,
  input  logic [REG_W-1:0]           latchIn,
  output logic [DATA_W-1:0]          busDataOut,
  output logic [REG_COUNT*REG_W-1:0] regFlat
);
  logic [REG_W-1:0]  slotVal;
  logic [DATA_W-1:0] byteOut;

  for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
    for (genvar b = 0; b < BYTES_PER_REG; b++) begin : g_byte
      logic [DATA_W-1:0] byteQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          byteQ <= '0;
        end else if (stb.regWe[r] && stb.byteIdx == BYTE_IDX_W'(b)) begin
          byteQ <= stb.wrByte;
        end
      end
      assign regFlat[(r*BYTES_PER_REG + b)*DATA_W +: DATA_W] = byteQ;
    end
  end

  always_comb begin
    slotVal = latchIn;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (stb.regIdx == REG_IDX_W'(i)) slotVal = regFlat[i*REG_W +: REG_W];
    end
    byteOut = '0;
    for (int b = 0; b < BYTES_PER_REG; b++) begin
      if (stb.byteIdx == BYTE_IDX_W'(b)) byteOut = slotVal[b*DATA_W +: DATA_W];
    end
  end

  assign busDataOut = cmdSel ? statusIn : byteOut;
endmodule

// File: rtl/ctr_bus_if.sv
module ctr_bus_if
  import ctr_bus_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busData,
  input  logic              cmdSel,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [REG_W-1:0]  latchIn,
  output logic [DATA_W-1:0] busDataOut,
  output logic              sysMode,
  output logic              loadStb,
  output logic              latchStb,
  output logic [REG_W-1:0]  preloadVal,
  output logic [REG_W-1:0]  cmpAVal,
  output logic [REG_W-1:0]  cmpBVal
);
  strobeT                     stb;
  logic [REG_COUNT*REG_W-1:0] regFlat;
  logic [REG_IDX_W-1:0]       curReg;
  logic [BYTE_IDX_W-1:0]      curByte;

  ctr_bus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busData(busData), .cmdSel(cmdSel),
    .wrStb(wrStb), .rdStb(rdStb), .stb(stb), .sysMode(sysMode),
    .loadStb(loadStb), .latchStb(latchStb)
  );

  ctr_bus_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdSel(cmdSel),
    .statusIn(statusIn), .latchIn(latchIn),
    .busDataOut(busDataOut), .regFlat(regFlat)
  );

  assign curReg     = stb.regIdx;
  assign curByte    = stb.byteIdx;
  assign preloadVal = regFlat[0*REG_W +: REG_W];
  assign cmpAVal    = regFlat[1*REG_W +: REG_W];
  assign cmpBVal    = regFlat[2*REG_W +: REG_W];
endmodule

// File: rtl/ctr_bus_chk.sv
module ctr_bus_chk
  import ctr_bus_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic [DATA_W-1:0]     busData,
  input logic                  cmdSel,
  input logic                  wrStb,
  input logic                  rdStb,
  input logic                  sysMode,
  input logic                  loadStb,
  input logic                  latchStb,
  input logic [REG_W-1:0]      preloadVal,
  input logic [REG_IDX_W-1:0]  curReg,
  input logic [BYTE_IDX_W-1:0] curByte
);
  p_mode1_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && cmdSel && busData == CMD_MODE1) |=> sysMode);

  p_mode0_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && cmdSel && busData == CMD_MODE0) |=> !sysMode);

  p_slice_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !cmdSel && curReg == '0 && curByte == '0)
      |=> ($stable(preloadVal[REG_W-1:DATA_W]) && preloadVal[DATA_W-1:0] == $past(busData)));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdSel && (wrStb || rdStb) && int'(curByte) == BYTES_PER_REG - 1) |=> curByte == '0);

  p_status_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSel && rdStb && !wrStb) |=> ($stable(curByte) && $stable(curReg)));

  p_load_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> $past(wrStb && cmdSel && busData == CMD_LOAD));

  p_latch_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    latchStb |-> $past(wrStb && cmdSel && busData == CMD_LATCH));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!wrStb && !rdStb) |=> ($stable(curByte) && $stable(curReg)));
endmodule

bind ctr_bus_if ctr_bus_chk u_chk (
  .clk(clk), .rstN(rstN), .busData(busData), .cmdSel(cmdSel),
  .wrStb(wrStb), .rdStb(rdStb), .sysMode(sysMode), .loadStb(loadStb),
  .latchStb(latchStb), .preloadVal(preloadVal), .curReg(curReg),
  .curByte(curByte)
);

// File: tb/sim_ctr_bus_if.sv
`timescale 1ns/1ps
module sim_ctr_bus_if;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busData = '0;
  logic        cmdSel = 1'b0, wrStb = 1'b0, rdStb = 1'b0;
  logic [7:0]  statusIn = 8'h5A;
  logic [23:0] latchIn = 24'hA1B2C3;
  logic [7:0]  busDataOut;
  logic        sysMode, loadStb, latchStb;
  logic [23:0] preloadVal, cmpAVal, cmpBVal;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  ctr_bus_if u0 (
    .clk(clk), .rstN(rstN), .busData(busData), .cmdSel(cmdSel),
    .wrStb(wrStb), .rdStb(rdStb), .statusIn(statusIn), .latchIn(latchIn),
    .busDataOut(busDataOut), .sysMode(sysMode), .loadStb(loadStb),
    .latchStb(latchStb), .preloadVal(preloadVal), .cmpAVal(cmpAVal),
    .cmpBVal(cmpBVal)
  );

  // op: 0 command write, 1 data write, 2 data read, 3 status read
  localparam int NVEC = 34;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, 8'h00, 8'h00}, {2'd1, 8'h11, 8'h00}, {2'd1, 8'h22, 8'h00},
    {2'd1, 8'h33, 8'h00}, {2'd2, 8'h00, 8'h11}, {2'd2, 8'h00, 8'h22},
    {2'd2, 8'h00, 8'h33}, {2'd2, 8'h00, 8'h11}, {2'd0, 8'h06, 8'h00},
    {2'd1, 8'h44, 8'h00}, {2'd1, 8'h55, 8'h00}, {2'd0, 8'h04, 8'h00},
    {2'd2, 8'h00, 8'h55}, {2'd2, 8'h00, 8'h00}, {2'd2, 8'h00, 8'h44},
    {2'd0, 8'h0C, 8'h00}, {2'd2, 8'h00, 8'hC3}, {2'd2, 8'h00, 8'hB2},
    {2'd2, 8'h00, 8'hA1}, {2'd3, 8'h00, 8'h5A}, {2'd0, 8'h0D, 8'h00},
    {2'd3, 8'h00, 8'h5A}, {2'd2, 8'h00, 8'hB2}, {2'd0, 8'h0B, 8'h00},
    {2'd1, 8'h77, 8'h00}, {2'd0, 8'h08, 8'h00}, {2'd2, 8'h00, 8'h77},
    {2'd0, 8'h0C, 8'h00}, {2'd1, 8'hEE, 8'h00}, {2'd2, 8'h00, 8'hB2},
    {2'd0, 8'h00, 8'h00}, {2'd2, 8'h00, 8'h11}, {2'd0, 8'h55, 8'h00},
    {2'd2, 8'h00, 8'h22}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busOp(input logic [1:0] op, input logic [7:0] data, input logic [7:0] exp);
    @(negedge clk);
    busData = data;
    cmdSel  = (op == 2'd0) || (op == 2'd3);
    wrStb   = (op == 2'd0) || (op == 2'd1);
    rdStb   = (op == 2'd2) || (op == 2'd3);
    #1;
    if (op == 2'd2) check("R5 R6 data read", {24'h0, busDataOut}, {24'h0, exp});
    if (op == 2'd3) check("R7 status read", {24'h0, busDataOut}, {24'h0, exp});
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    wrStb = 1'b0; rdStb = 1'b0; cmdSel = 1'b0; busData = '0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 mode", {31'h0, sysMode}, 32'h0);
    check("R1 preload", {8'h0, preloadVal}, 32'h0);
    check("R1 strobes", {30'h0, loadStb, latchStb}, 32'h0);
    busOp(2'd1, 8'hAA, 8'h00);
    idle();
    check("R1 pointer at slot0 low", {8'h0, preloadVal}, 32'h0000AA);

    for (int i = 0; i < NVEC; i++) busOp(VEC[i][17:16], VEC[i][15:8], VEC[i][7:0]);
    idle();
    check("R4 preload lanes", {8'h0, preloadVal}, 32'h332211);
    check("R4 compareA lanes", {8'h0, cmpAVal}, 32'h440055);
    check("R3 R8 compareB", {8'h0, cmpBVal}, 32'h000077);

    // R2 mode commands and ignored byte
    busOp(2'd0, 8'h91, 8'h00); idle();
    check("R2 mode1", {31'h0, sysMode}, 32'h1);
    busOp(2'd0, 8'h55, 8'h00); idle();
    check("R10 unknown cmd keeps mode", {31'h0, sysMode}, 32'h1);
    busOp(2'd0, 8'h90, 8'h00); idle();
    check("R2 mode0", {31'h0, sysMode}, 32'h0);

    // R9 strobes
    busOp(2'd0, 8'h20, 8'h00); idle();
    check("R9 load pulse", {30'h0, loadStb, latchStb}, 32'h2);
    idle();
    check("R9 load ends", {30'h0, loadStb, latchStb}, 32'h0);
    busOp(2'd0, 8'h21, 8'h00); idle();
    check("R9 latch pulse", {30'h0, loadStb, latchStb}, 32'h1);
    idle();
    check("R9 latch ends", {30'h0, loadStb, latchStb}, 32'h0);

    // R10 idle cycles do not move the pointer
    busOp(2'd0, 8'h01, 8'h00);
    repeat (4) idle();
    busOp(2'd2, 8'h00, 8'h22);
    idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule